// File: doc/BRIEF.md
# Privileged Model-Specific Register Read Unit

This unit carries out the "read a model-specific register" operation inside a simple core model. On a one-cycle `start` pulse it takes the two decoded opcode bytes, a bus-lock prefix flag, the current privilege level, the operating mode and the 64-bit index register. It then decides whether the read may proceed and looks the index up in a small parameterised table of implemented 64-bit registers.

A permitted read splits the 64-bit value over two 64-bit destination registers: the accumulator gets the lower half and the data register gets the upper half, each zero-extended. A refused read raises either an invalid-opcode fault or a protection fault with error code zero, and in that case neither destination is written. The flags word passes through unchanged in every case. Results, fault and a `done` strobe appear one cycle after `start`.

Top module: `regrd_unit`

## Requirements
- R1: The operation is recognised only when `op_b0` is 0x0F and `op_b1` is 0x32. Any other byte pair raises an invalid-opcode fault (`fault_kind` = 2'b01).
- R2: When `lock_pfx` is set, the result is an invalid-opcode fault, whatever the privilege, mode or index. This check comes before every other fault.
- R3: `op_mode` is encoded as 2'b00 real-address, 2'b01 protected, 2'b10 virtual-8086 and 2'b11 64-bit. In real-address mode any privilege level may read. In protected and 64-bit modes a `priv_lvl` other than 0 raises a protection fault (`fault_kind` = 2'b10) with `fault_err` = 0. This check comes before the index check.
- R4: In virtual-8086 mode the operation always raises a protection fault with `fault_err` = 0, even at privilege level 0 and with a valid index.
- R5: Only bits 31:0 of `idx_reg` select the table entry. Bits 63:32 are ignored.
- R6: An index that matches no table entry whose valid bit is set raises a protection fault with `fault_err` = 0. This includes an entry whose index matches but whose valid bit is clear.
- R7: On success, `acc_out[31:0]` carries value bits 31:0 and `dat_out[31:0]` carries value bits 63:32. Bits 63:32 of both outputs are zero, and `acc_we` and `dat_we` are both 1.
- R8: Each entry has an implemented-bits mask. Value bits outside the mask read as zero.
- R9: On any fault, `fault_vld` is 1, `acc_we` and `dat_we` are 0, and `acc_out` and `dat_out` are zero.
- R10: `done` rises in the cycle after each `start` and lasts one cycle per start. Back-to-back starts give back-to-back results. Without `start`, `done`, `fault_vld` and both write enables are 0.
- R11: `flags_out` equals the `flags_in` value sampled with `start`, on success and on fault alike.
- R12: While `rst` is high, all outputs are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to execute |
| op_b0 | input | 8 | First opcode byte |
| op_b1 | input | 8 | Second opcode byte |
| lock_pfx | input | 1 | Bus-lock prefix present |
| priv_lvl | input | 2 | Current privilege level |
| op_mode | input | 2 | Operating mode |
| idx_reg | input | 64 | Index register |
| flags_in | input | 32 | Flags before execution |
| done | output | 1 | Completion strobe |
| acc_we | output | 1 | Accumulator write enable |
| dat_we | output | 1 | Data register write enable |
| acc_out | output | 64 | Accumulator result |
| dat_out | output | 64 | Data register result |
| fault_vld | output | 1 | A fault was raised |
| fault_kind | output | 2 | 01 invalid opcode, 10 protection |
| fault_err | output | 16 | Fault error code |
| flags_out | output | 32 | Flags after execution |

## Verification
The main function is tried with every valid table entry across real, protected and 64-bit modes. These cases separate the lower/upper split from a swapped split, and full-width entries from masked ones. Indices with junk in bits 63:32, and an index whose only set bit lies above bit 31, show that the upper half is ignored and does not alias. Refused reads vary one condition at a time (privilege, virtual-8086 mode, invalid entry, unknown index, opcode bytes, lock prefix), and combined cases confirm that the lock fault outranks the rest. Back-to-back starts, idle cycles and reset in mid-stream cover the strobe timing.

// File: rtl/regrd_pkg.sv
package regrd_pkg;

    localparam int NUM_ENT = 8;
    localparam int IDX_W   = 32;
    localparam int VAL_W   = 64;
    localparam int REG_W   = 64;
    localparam int HALF_W  = VAL_W / 2;
    localparam int FLAGS_W = 32;
    localparam int ERR_W   = 16;

    localparam logic [7:0] OPC_ESC  = 8'h0F;
    localparam logic [7:0] OPC_READ = 8'h32;

    typedef enum logic [1:0] {
        MODE_REAL = 2'b00,
        MODE_PROT = 2'b01,
        MODE_V86  = 2'b10,
        MODE_LONG = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        FK_NONE  = 2'b00,
        FK_BADOP = 2'b01,
        FK_PROT  = 2'b10
    } fault_e;

    typedef struct packed {
        logic              hit;
        logic [VAL_W-1:0]  val;
    } look_t;

    typedef struct packed {
        logic [REG_W-1:0] acc;
        logic [REG_W-1:0] dat;
    } split_t;

    // Default table contents, one entry per case arm.
    function automatic logic [IDX_W-1:0] dflt_idx(input int unsigned e);
        case (e)
            0: return 32'h0000_0010;
            1: return 32'h0000_001B;
            2: return 32'h0000_003A;
            3: return 32'h0000_0174;
            4: return 32'h0000_0175;
            5: return 32'h0000_0176;
            6: return 32'hC000_0080;
            default: return 32'h0000_0277;
        endcase
    endfunction

    function automatic logic [VAL_W-1:0] dflt_val(input int unsigned e);
        case (e)
            0: return 64'h0123_4567_89AB_CDEF;
            1: return 64'hFEE0_0000_0000_0900;
            2: return 64'h0000_0000_0000_0005;
            3: return 64'hDEAD_BEEF_CAFE_F00D;
            4: return 64'h1111_2222_3333_4444;
            5: return 64'h8000_0000_0000_0001;
            6: return 64'h0000_0000_0000_0D01;
            default: return 64'h0007_0406_0007_0406;
        endcase
    endfunction

    function automatic logic [VAL_W-1:0] dflt_mask(input int unsigned e);
        case (e)
            3: return 64'h0000_0000_FFFF_FFFF;
            4: return 64'h0000_FFFF_FFFF_FFFF;
            default: return {VAL_W{1'b1}};
        endcase
    endfunction

    function automatic logic [NUM_ENT-1:0][IDX_W-1:0] dflt_idx_all();
        logic [NUM_ENT-1:0][IDX_W-1:0] r;
        for (int i = 0; i < NUM_ENT; i++) r[i] = dflt_idx(i);
        return r;
    endfunction

    function automatic logic [NUM_ENT-1:0][VAL_W-1:0] dflt_val_all();
        logic [NUM_ENT-1:0][VAL_W-1:0] r;
        for (int i = 0; i < NUM_ENT; i++) r[i] = dflt_val(i);
        return r;
    endfunction

    function automatic logic [NUM_ENT-1:0][VAL_W-1:0] dflt_mask_all();
        logic [NUM_ENT-1:0][VAL_W-1:0] r;
        for (int i = 0; i < NUM_ENT; i++) r[i] = dflt_mask(i);
        return r;
    endfunction

    // Entry 7 is present in the table but marked not implemented.
    localparam logic [NUM_ENT-1:0] DFLT_VLD = 8'b0111_1111;

    function automatic logic [REG_W-1:0] zext_half(input logic [HALF_W-1:0] h);
        return {{(REG_W-HALF_W){1'b0}}, h};
    endfunction

endpackage

// File: rtl/regrd_gate.sv
module regrd_gate
    import regrd_pkg::*;
(
    input  logic [7:0] op_b0,
    input  logic [7:0] op_b1,
    input  logic       lock_pfx,
    input  logic [1:0] priv_lvl,
    input  logic [1:0] op_mode,
    output fault_e     pre_fault
);
    op_mode_e mode;
    logic     opc_ok;
    logic     priv_ok;

    always_comb begin
        mode    = op_mode_e'(op_mode);
        opc_ok  = (op_b0 == OPC_ESC) && (op_b1 == OPC_READ);
        unique case (mode)
            MODE_REAL:            priv_ok = 1'b1;
            MODE_PROT, MODE_LONG: priv_ok = (priv_lvl == 2'd0);
            default:              priv_ok = 1'b0;
        endcase
        // Fixed order: opcode or lock first, then permission.
        if (lock_pfx || !opc_ok)
            pre_fault = FK_BADOP;
        else if (!priv_ok)
            pre_fault = FK_PROT;
        else
            pre_fault = FK_NONE;
    end
endmodule

// File: rtl/regrd_table.sv
module regrd_table
    import regrd_pkg::*;
#(
    parameter int N_ENT = NUM_ENT,
    parameter logic [N_ENT-1:0][IDX_W-1:0] T_IDX  = dflt_idx_all(),
    parameter logic [N_ENT-1:0][VAL_W-1:0] T_VAL  = dflt_val_all(),
    parameter logic [N_ENT-1:0][VAL_W-1:0] T_MASK = dflt_mask_all(),
    parameter logic [N_ENT-1:0]            T_VLD  = DFLT_VLD
) (
    input  logic [IDX_W-1:0] idx,
    output look_t            res
);
    logic [N_ENT-1:0]            hit;
    logic [N_ENT-1:0][VAL_W-1:0] shown;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign hit[g]   = T_VLD[g] && (idx == T_IDX[g]);
        assign shown[g] = T_VAL[g] & T_MASK[g];
    end

    // Lowest-numbered matching entry wins if indices repeat.
    always_comb begin
        res = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                res.hit = 1'b1;
                res.val = shown[i];
            end
        end
    end
endmodule

// File: rtl/regrd_split.sv
module regrd_split
    import regrd_pkg::*;
(
    input  logic [VAL_W-1:0] val,
    output split_t           out
);
    always_comb begin
        out.acc = zext_half(val[HALF_W-1:0]);
        out.dat = zext_half(val[VAL_W-1:HALF_W]);
    end
endmodule

// File: rtl/regrd_unit.sv
module regrd_unit
    import regrd_pkg::*;
#(
    parameter int N_ENT = NUM_ENT,
    parameter logic [N_ENT-1:0][IDX_W-1:0] T_IDX  = dflt_idx_all(),
    parameter logic [N_ENT-1:0][VAL_W-1:0] T_VAL  = dflt_val_all(),
    parameter logic [N_ENT-1:0][VAL_W-1:0] T_MASK = dflt_mask_all(),
    parameter logic [N_ENT-1:0]            T_VLD  = DFLT_VLD
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [7:0]         op_b0,
    input  logic [7:0]         op_b1,
    input  logic               lock_pfx,
    input  logic [1:0]         priv_lvl,
    input  logic [1:0]         op_mode,
    input  logic [63:0]        idx_reg,
    input  logic [FLAGS_W-1:0] flags_in,
    output logic               done,
    output logic               acc_we,
    output logic               dat_we,
    output logic [REG_W-1:0]   acc_out,
    output logic [REG_W-1:0]   dat_out,
    output logic               fault_vld,
    output logic [1:0]         fault_kind,
    output logic [ERR_W-1:0]   fault_err,
    output logic [FLAGS_W-1:0] flags_out
);
    fault_e pre_fault;
    fault_e fin_fault;
    look_t  look;
    split_t halves;
    logic   unused_idx_hi;

    // Upper index half takes no part in selection.
    assign unused_idx_hi = ^idx_reg[63:IDX_W];

    regrd_gate u_gate (
        .op_b0     (op_b0),
        .op_b1     (op_b1),
        .lock_pfx  (lock_pfx),
        .priv_lvl  (priv_lvl),
        .op_mode   (op_mode),
        .pre_fault (pre_fault)
    );

    regrd_table #(
        .N_ENT  (N_ENT),
        .T_IDX  (T_IDX),
        .T_VAL  (T_VAL),
        .T_MASK (T_MASK),
        .T_VLD  (T_VLD)
    ) u_table (
        .idx (idx_reg[IDX_W-1:0]),
        .res (look)
    );

    regrd_split u_split (
        .val (look.val),
        .out (halves)
    );

    always_comb begin
        if (pre_fault != FK_NONE) fin_fault = pre_fault;
        else if (!look.hit)       fin_fault = FK_PROT;
        else                      fin_fault = FK_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            acc_we     <= 1'b0;
            dat_we     <= 1'b0;
            acc_out    <= '0;
            dat_out    <= '0;
            fault_vld  <= 1'b0;
            fault_kind <= FK_NONE;
            fault_err  <= '0;
            flags_out  <= '0;
        end else begin
            done <= start;
            if (start) begin
                flags_out  <= flags_in;
                fault_kind <= fin_fault;
                fault_err  <= '0;
                if (fin_fault == FK_NONE) begin
                    acc_we    <= 1'b1;
                    dat_we    <= 1'b1;
                    acc_out   <= halves.acc;
                    dat_out   <= halves.dat;
                    fault_vld <= 1'b0;
                end else begin
                    acc_we    <= 1'b0;
                    dat_we    <= 1'b0;
                    acc_out   <= '0;
                    dat_out   <= '0;
                    fault_vld <= 1'b1;
                end
            end else begin
                acc_we    <= 1'b0;
                dat_we    <= 1'b0;
                fault_vld <= 1'b0;
            end
        end
    end

    // ---------------- assertions ----------------
    p_bad_bytes_r1: assert property (@(posedge clk) disable iff (rst)
        start && !lock_pfx && (op_b0 != OPC_ESC) |=> fault_vld && fault_kind == FK_BADOP);

    p_lock_first_r2: assert property (@(posedge clk) disable iff (rst)
        start && lock_pfx |=> fault_vld && fault_kind == FK_BADOP);

    p_user_level_r3: assert property (@(posedge clk) disable iff (rst)
        start && !lock_pfx && op_b0 == OPC_ESC && op_b1 == OPC_READ
        && (op_mode == MODE_PROT || op_mode == MODE_LONG) && priv_lvl != 2'd0
        |=> fault_vld && fault_kind == FK_PROT && fault_err == '0);

    p_v86_refused_r4: assert property (@(posedge clk) disable iff (rst)
        start && !lock_pfx && op_b0 == OPC_ESC && op_b1 == OPC_READ && op_mode == MODE_V86
        |=> fault_vld && fault_kind == FK_PROT);

    p_upper_clear_r7: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> acc_out[REG_W-1:HALF_W] == '0 && dat_out[REG_W-1:HALF_W] == '0 && dat_we);

    p_fault_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        fault_vld |-> !acc_we && !dat_we && acc_out == '0 && dat_out == '0);

    p_done_follows_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));

    p_start_done_r10: assert property (@(posedge clk) disable iff (rst)
        start |=> done && $countones({acc_we, fault_vld}) == 1);

    p_flags_kept_r11: assert property (@(posedge clk) disable iff (rst)
        start |=> flags_out == $past(flags_in));

endmodule

// File: tb/sim_regrd_unit.sv
module sim_regrd_unit;
    import regrd_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic               start;
    logic [7:0]         op_b0, op_b1;
    logic               lock_pfx;
    logic [1:0]         priv_lvl, op_mode;
    logic [63:0]        idx_reg;
    logic [31:0]        flags_in;
    logic               done, acc_we, dat_we, fault_vld;
    logic [63:0]        acc_out, dat_out;
    logic [1:0]         fault_kind;
    logic [15:0]        fault_err;
    logic [31:0]        flags_out;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    regrd_unit u0 (
        .clk(clk), .rst(rst), .start(start), .op_b0(op_b0), .op_b1(op_b1),
        .lock_pfx(lock_pfx), .priv_lvl(priv_lvl), .op_mode(op_mode),
        .idx_reg(idx_reg), .flags_in(flags_in), .done(done), .acc_we(acc_we),
        .dat_we(dat_we), .acc_out(acc_out), .dat_out(dat_out),
        .fault_vld(fault_vld), .fault_kind(fault_kind), .fault_err(fault_err),
        .flags_out(flags_out)
    );

    typedef struct packed {
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic        lk;
        logic [1:0]  pl;
        logic [1:0]  md;
        logic [63:0] idx;
        logic [31:0] fl;
        logic [1:0]  kind;   // 0 ok, 1 invalid opcode, 2 protection
        logic [31:0] lo;
        logic [31:0] hi;
    } vec_t;

    localparam int NV = 18;
    // md: 0 real, 1 protected, 2 virtual-8086, 3 64-bit
    localparam vec_t VT [NV] = '{
        '{8'h0F, 8'h32, 1'b0, 2'd0, 2'd3, 64'h10,                  32'h0000_0202, 2'd0, 32'h89AB_CDEF, 32'h0123_4567}, // R7
        '{8'h0F, 8'h32, 1'b0, 2'd0, 2'd1, 64'h1B,                  32'h0000_08D5, 2'd0, 32'h0000_0900, 32'hFEE0_0000}, // R7
        '{8'h0F, 8'h32, 1'b0, 2'd3, 2'd0, 64'h3A,                  32'h0000_0001, 2'd0, 32'h0000_0005, 32'h0000_0000}, // R3 real any level
        '{8'h0F, 8'h32, 1'b0, 2'd0, 2'd3, 64'h174,                 32'h0000_0046, 2'd0, 32'hCAFE_F00D, 32'h0000_0000}, // R8
        '{8'h0F, 8'h32, 1'b0, 2'd0, 2'd1, 64'h175,                 32'h0000_0081, 2'd0, 32'h3333_4444, 32'h0000_2222}, // R8
        '{8'h0F, 8'h32, 1'b0, 2'd0, 2'd3, 64'hFFFF_FFFF_0000_0176, 32'h0000_0ED7, 2'd0, 32'h0000_0001, 32'h8000_0000}, // R5
        '{8'h0F, 8'h32, 1'b0, 2'd0, 2'd3, 64'h0000_0000_C000_0080, 32'h0000_0010, 2'd0, 32'h0000_0D01, 32'h0000_0000}, // R7
        '{8'h0F, 8'h32, 1'b0, 2'd3, 2'd3, 64'h10,                  32'h0000_0203, 2'd2, 32'h0,         32'h0},         // R3
        '{8'h0F, 8'h32, 1'b0, 2'd1, 2'd1, 64'h10,                  32'h0000_0044, 2'd2, 32'h0,         32'h0},         // R3
        '{8'h0F, 8'h32, 1'b0, 2'd0, 2'd2, 64'h10,                  32'h0002_0002, 2'd2, 32'h0,         32'h0},         // R4
        '{8'h0F, 8'h32, 1'b0, 2'd0, 2'd3, 64'h277,                 32'h0000_0C95, 2'd2, 32'h0,         32'h0},         // R6 invalid entry
        '{8'h0F, 8'h32, 1'b0, 2'd0, 2'd0, 64'h999,                 32'h0000_0004, 2'd2, 32'h0,         32'h0},         // R6 unknown
        '{8'h0F, 8'h32, 1'b0, 2'd0, 2'd3, 64'h1_0000_0000,         32'h0000_0800, 2'd2, 32'h0,         32'h0},         // R5 no alias
        '{8'h0F, 8'h32, 1'b1, 2'd0, 2'd3, 64'h10,                  32'h0000_0080, 2'd1, 32'h0,         32'h0},         // R2
        '{8'h0F, 8'h32, 1'b1, 2'd3, 2'd2, 64'h999,                 32'h0000_0001, 2'd1, 32'h0,         32'h0},         // R2 outranks
        '{8'h0F, 8'h33, 1'b0, 2'd0, 2'd3, 64'h10,                  32'h0000_0040, 2'd1, 32'h0,         32'h0},         // R1
        '{8'h0E, 8'h32, 1'b0, 2'd0, 2'd3, 64'h10,                  32'h0000_0400, 2'd1, 32'h0,         32'h0},         // R1
        '{8'h0F, 8'h32, 1'b0, 2'd3, 2'd1, 64'h999,                 32'h0000_0010, 2'd2, 32'h0,         32'h0}          // R3 before R6
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_b0 = v.b0; op_b1 = v.b1; lock_pfx = v.lk; priv_lvl = v.pl;
        op_mode = v.md; idx_reg = v.idx; flags_in = v.fl; start = 1'b1;
    endtask

    task automatic expect_vec(input vec_t v, input int k);
        string t;
        t = $sformatf("R10 v%0d done", k);
        chk(done === 1'b1, t, {63'd0, done}, 64'd1);
        t = $sformatf("R2/R3/R4/R6 v%0d kind", k);
        chk(fault_kind === v.kind, t, {62'd0, fault_kind}, {62'd0, v.kind});
        t = $sformatf("R9 v%0d fault_vld/we", k);
        chk({fault_vld, acc_we, dat_we} === ((v.kind == 2'd0) ? 3'b011 : 3'b100), t,
            {61'd0, fault_vld, acc_we, dat_we}, (v.kind == 2'd0) ? 64'd3 : 64'd4);
        t = $sformatf("R7 v%0d acc", k);
        chk(acc_out === {32'd0, v.lo}, t, acc_out, {32'd0, v.lo});
        t = $sformatf("R7 v%0d dat", k);
        chk(dat_out === {32'd0, v.hi}, t, dat_out, {32'd0, v.hi});
        t = $sformatf("R11 v%0d flags", k);
        chk(flags_out === v.fl, t, {32'd0, flags_out}, {32'd0, v.fl});
        t = $sformatf("R3 v%0d err", k);
        chk(fault_err === 16'd0, t, {48'd0, fault_err}, 64'd0);
    endtask

    task automatic check_idle(input string tag);
        chk({done, fault_vld, acc_we, dat_we} === 4'b0000, tag,
            {60'd0, done, fault_vld, acc_we, dat_we}, 64'd0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; op_b0 = '0; op_b1 = '0; lock_pfx = 1'b0;
        priv_lvl = '0; op_mode = '0; idx_reg = '0; flags_in = '0;
        repeat (3) @(negedge clk);

        // R12 reset state, with start asserted during reset
        drive(VT[0]);
        @(negedge clk);
        check_idle("R12 reset strobes");
        chk(acc_out === 64'd0 && dat_out === 64'd0, "R12 reset data", acc_out, 64'd0);
        chk(fault_kind === 2'd0 && flags_out === 32'd0, "R12 reset kind/flags",
            {30'd0, fault_kind, flags_out}, 64'd0);
        start = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_idle("R10 no start after reset");

        // table walk
        for (int k = 0; k < NV; k++) begin
            drive(VT[k]);
            @(negedge clk);
            start = 1'b0;
            expect_vec(VT[k], k);
            @(negedge clk);
            check_idle($sformatf("R10 v%0d single pulse", k));
        end

        // R10 back-to-back starts
        drive(VT[3]);
        @(negedge clk);
        drive(VT[9]);
        expect_vec(VT[3], 100);
        @(negedge clk);
        drive(VT[1]);
        expect_vec(VT[9], 101);
        @(negedge clk);
        start = 1'b0;
        expect_vec(VT[1], 102);

        // R10 long idle: inputs wiggle but no start
        for (int i = 0; i < 5; i++) begin
            op_b0 = 8'h0F; op_b1 = 8'h32; idx_reg = 64'h10 + i; flags_in = 32'hFFFF_0000 + i;
            @(negedge clk);
            check_idle($sformatf("R10 idle %0d", i));
        end
        chk(dat_out === {32'd0, 32'hFEE0_0000}, "R10 data held while idle", dat_out,
            {32'd0, 32'hFEE0_0000});

        // R12 reset in mid-stream
        drive(VT[0]);
        rst = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_idle("R12 reset mid-stream");
        chk(acc_out === 64'd0 && flags_out === 32'd0, "R12 reset clears data", acc_out, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule